// File: doc/BRIEF.md
# Interrupt Claim-Complete Controller

This block gathers level interrupt requests from a set of sources and presents one interrupt line to each of several targets (contexts). A simple 32-bit register port gives software access to a priority per source, a threshold per context, a read-only view of the pending bits, and an enable word set per context. Each context has its own arbiter that always knows which eligible source currently wins. Eligible means pending, enabled for that context, not already claimed, and with a priority above the context's threshold.

Software services an interrupt in two steps. It reads the context's claim/complete register, which returns the winning source ID. That same access marks the source as claimed and drops its pending bit. When the handler is done, software writes the ID back to the same register, which releases the claim. Priority and threshold writes are legalised. When the number of levels is a power of two the stored value wraps. Otherwise an out-of-range value is dropped.

Requests are sticky. A pulse on a request input leaves the source pending until a claim takes it. Source 0 is reserved: it never becomes pending and its priority is fixed at zero.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset every priority, threshold, pending, claimed and enable bit is 0, every `ctx_irq` bit is low and `reg_rvalid` is low.
- R2: A read request (`reg_valid`=1, `reg_we`=0) returns its data on `reg_rdata` with `reg_rvalid` high on the clock edge after the request. Reads of unmapped or non-word-aligned addresses return 0. Writes to such addresses change nothing.
- R3: The priority of source N is the word at `PRIO_BASE + 4*N`. Source 0 always reads 0 and ignores writes.
- R4: A priority or threshold write is legalised. If `MAX_PRIO+1` is a power of two, the value stored is the written value modulo `MAX_PRIO+1`. Otherwise a value above `MAX_PRIO` is discarded and the old value is kept.
- R5: Pending word w sits at `PEND_BASE + 4*w`, and its bit i is source 32*w+i. Pending words are read-only, so writes to them are ignored. Bit 0 (source 0) is always 0.
- R6: A source request that is high at a clock edge sets that source's pending bit. Dropping the request does not clear the bit. Only a claim clears it.
- R7: Enable word w of context C sits at `EN_BASE + C*EN_STRIDE + 4*w`, and its bit i enables source 32*w+i. A word index at or beyond the number of pending words reads 0 and ignores writes. Bits for sources that do not exist read 0.
- R8: In the block of context C at `CTX_BASE + C*CTX_STRIDE`, offset 0 is the threshold and offset 4 is claim/complete. Any other offset reads 0 and ignores writes.
- R9: The winner of a context is the eligible source with the highest priority strictly above the threshold. Ties go to the lowest ID. The winner is 0 when no source is eligible. `ctx_irq[C]` is high exactly when the winner of C is nonzero, and it follows the register state without an extra cycle.
- R10: Reading claim/complete returns the winner. If the winner is nonzero, that same edge clears its pending bit and sets its claimed bit. The clear takes precedence over a request that is high at that edge.
- R11: Writing V to claim/complete clears the claimed bit of source V when V < `N_SRC`. A larger V is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| src_req | input | N_SRC | Level request per source (bit 0 unused) |
| ctx_irq | output | N_CTX | Interrupt line per context |

## Verification
A corrupted claimed bit shows at the ports either as a source that never raises its line again, or as the same ID returned twice by claim reads. A lost or spurious pending bit shows in the pending word and in `ctx_irq` one edge after the bad update. Because `ctx_irq` is combinational from the registered state, any wrong eligibility or priority comparison is visible in the cycle right after the edge that caused it. That makes a per-cycle comparison of every interrupt line and every read result against a behavioural model a tight net. Explicit reads then pin down the wrap/drop legalisation rules, claim side effects and ignored writes.

// File: rtl/irq_cc_pkg.sv
`timescale 1ns/1ps
package irq_cc_pkg;

    localparam int DW = 32;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_PEND,
        RG_EN,
        RG_CTX
    } region_e;

    typedef enum logic [1:0] {
        CS_THR,
        CS_CLAIM,
        CS_OTHER
    } ctx_sel_e;

    // index width for a count, never below one bit
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_cc_decode.sv
`timescale 1ns/1ps
module irq_cc_decode
    import irq_cc_pkg::*;
#(
    parameter int unsigned AW         = 12,
    parameter int unsigned N_SRC      = 8,
    parameter int unsigned N_CTX      = 2,
    parameter int unsigned NW         = 1,
    parameter int unsigned PRIO_BASE  = 32'h000,
    parameter int unsigned PEND_BASE  = 32'h080,
    parameter int unsigned EN_BASE    = 32'h100,
    parameter int unsigned EN_STRIDE  = 32'h020,
    parameter int unsigned CTX_BASE   = 32'h200,
    parameter int unsigned CTX_STRIDE = 32'h010,
    parameter int          SIW        = idx_w(N_SRC),
    parameter int          WIW        = idx_w(NW),
    parameter int          CIW        = idx_w(N_CTX)
) (
    input  logic [AW-1:0]  addr,
    output region_e        region,
    output logic [SIW-1:0] src_idx,
    output logic [WIW-1:0] word_idx,
    output logic [CIW-1:0] ctx_idx,
    output logic           word_ok,
    output ctx_sel_e       ctx_sel
);

    localparam int EN_SH = $clog2(EN_STRIDE);
    localparam int CX_SH = $clog2(CTX_STRIDE);

    logic [31:0] a;
    logic [31:0] off;
    logic [31:0] sub;

    always_comb begin
        a        = 32'(addr);
        off      = '0;
        sub      = '0;
        region   = RG_NONE;
        src_idx  = '0;
        word_idx = '0;
        ctx_idx  = '0;
        word_ok  = 1'b0;
        ctx_sel  = CS_OTHER;
        if (a[1:0] == 2'b00) begin
            if (a >= PRIO_BASE && (a - PRIO_BASE) < N_SRC * 4) begin
                region  = RG_PRIO;
                off     = a - PRIO_BASE;
                src_idx = SIW'(off >> 2);
            end else if (a >= PEND_BASE && (a - PEND_BASE) < NW * 4) begin
                region   = RG_PEND;
                off      = a - PEND_BASE;
                word_idx = WIW'(off >> 2);
            end else if (a >= EN_BASE && (a - EN_BASE) < N_CTX * EN_STRIDE) begin
                region   = RG_EN;
                off      = a - EN_BASE;
                ctx_idx  = CIW'(off >> EN_SH);
                sub      = (off & (EN_STRIDE - 1)) >> 2;
                word_ok  = (sub < NW);
                word_idx = WIW'(sub);
            end else if (a >= CTX_BASE && (a - CTX_BASE) < N_CTX * CTX_STRIDE) begin
                region  = RG_CTX;
                off     = a - CTX_BASE;
                ctx_idx = CIW'(off >> CX_SH);
                sub     = off & (CTX_STRIDE - 1);
                if (sub == 32'd0) begin
                    ctx_sel = CS_THR;
                end else if (sub == 32'd4) begin
                    ctx_sel = CS_CLAIM;
                end else begin
                    ctx_sel = CS_OTHER;
                end
            end
        end
    end

endmodule

// File: rtl/irq_cc_legal.sv
`timescale 1ns/1ps
module irq_cc_legal #(
    parameter int unsigned MAX_PRIO = 7,
    parameter int          PW       = $clog2(MAX_PRIO + 1)
) (
    input  logic [31:0]   wdata,
    output logic          ok,
    output logic [PW-1:0] value
);

    localparam bit POW2 = (((MAX_PRIO + 1) & MAX_PRIO) == 0);

    generate
        if (POW2) begin : g_wrap
            assign ok    = 1'b1;
            assign value = PW'(wdata % 32'(MAX_PRIO + 1));
        end else begin : g_drop
            assign ok    = (wdata <= 32'(MAX_PRIO));
            assign value = PW'(wdata);
        end
    endgenerate

endmodule

// File: rtl/irq_cc_arb.sv
`timescale 1ns/1ps
module irq_cc_arb #(
    parameter int N_SRC = 8,
    parameter int PW    = 3,
    parameter int SIW   = 3
) (
    input  logic [N_SRC-1:0]         pend,
    input  logic [N_SRC-1:0]         clm,
    input  logic [N_SRC-1:0]         en,
    input  logic [N_SRC-1:0][PW-1:0] prio,
    input  logic [PW-1:0]            thr,
    output logic [SIW-1:0]           win_id
);

    logic [PW-1:0] best_p;

    // strict compare keeps the lowest ID on a tie
    always_comb begin
        best_p = thr;
        win_id = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && en[i] && !clm[i] && (prio[i] > best_p)) begin
                best_p = prio[i];
                win_id = SIW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_claim_ctrl.sv
`timescale 1ns/1ps
module irq_claim_ctrl
    import irq_cc_pkg::*;
#(
    parameter int unsigned AW         = 12,
    parameter int unsigned N_SRC      = 8,
    parameter int unsigned N_CTX      = 2,
    parameter int unsigned MAX_PRIO   = 7,
    parameter int unsigned PRIO_BASE  = 32'h000,
    parameter int unsigned PEND_BASE  = 32'h080,
    parameter int unsigned EN_BASE    = 32'h100,
    parameter int unsigned EN_STRIDE  = 32'h020,
    parameter int unsigned CTX_BASE   = 32'h200,
    parameter int unsigned CTX_STRIDE = 32'h010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_valid,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_rvalid,
    input  logic [N_SRC-1:0] src_req,
    output logic [N_CTX-1:0] ctx_irq
);

    localparam int NW  = (N_SRC + 31) / 32;
    localparam int PW  = $clog2(MAX_PRIO + 1);
    localparam int SIW = idx_w(N_SRC);
    localparam int WIW = idx_w(NW);
    localparam int CIW = idx_w(N_CTX);
    localparam logic [N_SRC-1:0] REQ_MASK = {{(N_SRC-1){1'b1}}, 1'b0};

    typedef struct packed {
        logic [N_SRC-1:0][PW-1:0]    prio;
        logic [N_CTX-1:0][PW-1:0]    thr;
        logic [N_SRC-1:0]            pend;
        logic [N_SRC-1:0]            clm;
        logic [N_CTX-1:0][N_SRC-1:0] en;
        logic [31:0]                 rdata;
        logic                        rvalid;
    } state_t;

    state_t st_d, st_q;

    region_e        dec_region;
    logic [SIW-1:0] dec_src;
    logic [WIW-1:0] dec_word;
    logic [CIW-1:0] dec_ctx;
    logic           dec_word_ok;
    ctx_sel_e       dec_sel;

    logic           lg_ok;
    logic [PW-1:0]  lg_val;

    logic [N_CTX-1:0][SIW-1:0] win;
    logic [SIW-1:0]            win_sel;
    logic [N_SRC-1:0]          clr;
    logic                      rd_req;
    logic                      wr_req;
    logic                      claim_rd;

    irq_cc_decode #(
        .AW(AW), .N_SRC(N_SRC), .N_CTX(N_CTX), .NW(NW),
        .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
        .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
        .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE),
        .SIW(SIW), .WIW(WIW), .CIW(CIW)
    ) u_decode (
        .addr     (reg_addr),
        .region   (dec_region),
        .src_idx  (dec_src),
        .word_idx (dec_word),
        .ctx_idx  (dec_ctx),
        .word_ok  (dec_word_ok),
        .ctx_sel  (dec_sel)
    );

    irq_cc_legal #(
        .MAX_PRIO(MAX_PRIO), .PW(PW)
    ) u_legal (
        .wdata (reg_wdata),
        .ok    (lg_ok),
        .value (lg_val)
    );

    generate
        for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
            irq_cc_arb #(
                .N_SRC(N_SRC), .PW(PW), .SIW(SIW)
            ) u_arb (
                .pend   (st_q.pend),
                .clm    (st_q.clm),
                .en     (st_q.en[c]),
                .prio   (st_q.prio),
                .thr    (st_q.thr[c]),
                .win_id (win[c])
            );
            assign ctx_irq[c] = (win[c] != '0);

            // a raised line needs some enabled, pending, unclaimed source
            p_irq_has_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ctx_irq[c] |-> ((st_q.en[c] & st_q.pend & ~st_q.clm) != '0));

            p_thr_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (32'(st_q.thr[c]) <= MAX_PRIO));
        end
    endgenerate

    assign win_sel  = win[dec_ctx];
    assign rd_req   = reg_valid && !reg_we;
    assign wr_req   = reg_valid && reg_we;
    assign claim_rd = rd_req && (dec_region == RG_CTX) && (dec_sel == CS_CLAIM);

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_req;
        st_d.rdata  = '0;
        clr         = '0;

        if (rd_req) begin
            case (dec_region)
                RG_PRIO: st_d.rdata = 32'(st_q.prio[dec_src]);
                RG_PEND: begin
                    for (int b = 0; b < N_SRC; b++) begin
                        if ((b >> 5) == int'(dec_word)) begin
                            st_d.rdata[b & 31] = st_q.pend[b];
                        end
                    end
                end
                RG_EN: begin
                    if (dec_word_ok) begin
                        for (int b = 0; b < N_SRC; b++) begin
                            if ((b >> 5) == int'(dec_word)) begin
                                st_d.rdata[b & 31] = st_q.en[dec_ctx][b];
                            end
                        end
                    end
                end
                RG_CTX: begin
                    if (dec_sel == CS_THR) begin
                        st_d.rdata = 32'(st_q.thr[dec_ctx]);
                    end else if (dec_sel == CS_CLAIM) begin
                        st_d.rdata = 32'(win_sel);
                        if (win_sel != '0) begin
                            clr[win_sel]      = 1'b1;
                            st_d.clm[win_sel] = 1'b1;
                        end
                    end
                end
                default: st_d.rdata = '0;
            endcase
        end

        if (wr_req) begin
            case (dec_region)
                RG_PRIO: begin
                    if (dec_src != '0 && lg_ok) begin
                        st_d.prio[dec_src] = lg_val;
                    end
                end
                RG_EN: begin
                    if (dec_word_ok) begin
                        for (int b = 0; b < N_SRC; b++) begin
                            if ((b >> 5) == int'(dec_word)) begin
                                st_d.en[dec_ctx][b] = reg_wdata[b & 31];
                            end
                        end
                    end
                end
                RG_CTX: begin
                    if (dec_sel == CS_THR) begin
                        if (lg_ok) begin
                            st_d.thr[dec_ctx] = lg_val;
                        end
                    end else if (dec_sel == CS_CLAIM) begin
                        if (reg_wdata < 32'(N_SRC)) begin
                            st_d.clm[SIW'(reg_wdata)] = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end

        st_d.pend = (st_q.pend | (src_req & REQ_MASK)) & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata  = st_q.rdata;
    assign reg_rvalid = st_q.rvalid;

    p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> reg_rvalid);

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && dec_region == RG_NONE) |=> (reg_rdata == 32'd0));

    p_src0_inert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prio[0] == '0) && !st_q.pend[0]);

    p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(st_q.pend) & ~st_q.pend & ~st_q.clm) == '0));

    p_claim_marks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && win_sel != '0) |=>
            (st_q.clm[$past(win_sel)] && !st_q.pend[$past(win_sel)]));

endmodule

// File: tb/irq_claim_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_claim_ctrl_tb_top;

    localparam int N = 8;
    localparam int C = 2;
    localparam int LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [N-1:0] req = '0;
    logic [31:0] rdata, rdata5;
    logic        rvalid, rvalid5;
    logic [C-1:0] irq, irq5;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    always #10 clk = ~clk;

    irq_claim_ctrl #(.N_SRC(N), .N_CTX(C), .MAX_PRIO(7)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(vld), .reg_we(we),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .reg_rvalid(rvalid), .src_req(req), .ctx_irq(irq));

    irq_claim_ctrl #(.N_SRC(N), .N_CTX(C), .MAX_PRIO(5)) dut5_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(vld), .reg_we(we),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata5),
        .reg_rvalid(rvalid5), .src_req(req), .ctx_irq(irq5));

    // behavioural reference for dut_i
    int       m_prio[N];
    int       m_thr[C];
    bit       m_pend[N];
    bit       m_clm[N];
    bit [7:0] m_en[C];
    bit       m_rv;
    int       m_rd;

    function automatic int pa(int i); return i * 4; endfunction
    function automatic int ena(int c, int w); return 'h100 + c * 'h20 + w * 4; endfunction
    function automatic int tha(int c); return 'h200 + c * 'h10; endfunction
    function automatic int cla(int c); return 'h204 + c * 'h10; endfunction

    function automatic int m_win(int c);
        int best = 0;
        int bp = m_thr[c];
        for (int i = 0; i < N; i++) begin
            if (m_en[c][i] && m_pend[i] && !m_clm[i] && m_prio[i] > bp) begin
                best = i;
                bp = m_prio[i];
            end
        end
        return best;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_step();
        int a = int'(addr);
        int rd = 0;
        int wc = 0;
        bit rv = vld && !we;
        if (rv && a % 4 == 0) begin
            if (a < 'h20) rd = m_prio[a / 4];
            else if (a == 'h80) begin
                for (int i = 0; i < N; i++) rd[i] = m_pend[i];
            end else if (a >= 'h100 && a < 'h140) begin
                if (((a - 'h100) % 'h20) == 0) rd = int'(m_en[(a - 'h100) / 'h20]);
            end else if (a >= 'h200 && a < 'h220) begin
                if ((a - 'h200) % 16 == 0) rd = m_thr[(a - 'h200) / 16];
                else if ((a - 'h200) % 16 == 4) begin
                    wc = m_win((a - 'h200) / 16);
                    rd = wc;
                end
            end
        end
        for (int i = 1; i < N; i++) if (req[i]) m_pend[i] = 1'b1;
        if (wc > 0) begin
            m_pend[wc] = 1'b0;
            m_clm[wc] = 1'b1;
        end
        if (vld && we && a % 4 == 0) begin
            if (a < 'h20) begin
                if (a != 0) m_prio[a / 4] = int'(wdata % 8);
            end else if (a >= 'h100 && a < 'h140) begin
                if (((a - 'h100) % 'h20) == 0) m_en[(a - 'h100) / 'h20] = wdata[7:0];
            end else if (a >= 'h200 && a < 'h220) begin
                if ((a - 'h200) % 16 == 0) m_thr[(a - 'h200) / 16] = int'(wdata % 8);
                else if ((a - 'h200) % 16 == 4) begin
                    if (wdata < 8) m_clm[wdata] = 1'b0;
                end
            end
        end
        m_rv = rv;
        m_rd = rd;
    endtask

    // one clock: model follows the edge, outputs compared 1 ns later
    task automatic cyc();
        bit [C-1:0] mi;
        @(posedge clk);
        m_step();
        #1;
        for (int c = 0; c < C; c++) mi[c] = (m_win(c) != 0);
        chk(irq == mi, "R9 model irq", int'(irq), int'(mi));
        chk(rvalid == m_rv, "R2 model rvalid", int'(rvalid), int'(m_rv));
        if (m_rv) chk(rdata == m_rd, "R2 model rdata", int'(rdata), m_rd);
    endtask

    task automatic wr(input int a, input int d);
        vld = 1'b1; we = 1'b1; addr = 12'(a); wdata = d;
        cyc();
        vld = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        vld = 1'b1; we = 1'b0; addr = 12'(a);
        cyc();
        vld = 1'b0;
        chk(rdata == exp, tag, int'(rdata), exp);
    endtask

    task automatic pulse(input logic [N-1:0] r);
        req = r;
        cyc();
        req = '0;
        cyc();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > LIMIT) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog actual=%0d expected<=%0d", cyc_cnt, LIMIT);
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_prio[i] = 0; m_pend[i] = 0; m_clm[i] = 0;
        end
        for (int c = 0; c < C; c++) begin
            m_thr[c] = 0; m_en[c] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk(irq == '0, "R1 irq in reset", int'(irq), 0);
        chk(rvalid == 1'b0, "R1 rvalid in reset", int'(rvalid), 0);
        rst_n = 1'b1;
        cyc();
        rd(pa(3), 0, "R1 prio reset");
        rd(ena(0, 0), 0, "R1 enable reset");
        rd(tha(1), 0, "R1 threshold reset");
        rd('h80, 0, "R1 pending reset");

        // configuration
        wr(pa(3), 5); wr(pa(5), 2); wr(pa(2), 6); wr(pa(4), 6);
        wr(ena(0, 0), 'h3C); wr(ena(1, 0), 'h28); wr(tha(1), 4);
        rd(pa(3), 5, "R3 prio readback");

        // sticky pending, claim order
        pulse(8'h28);
        rd('h80, 'h28, "R6 pending sticky after pulse");
        chk(irq == 2'b11, "R9 both lines up", int'(irq), 3);
        rd(cla(0), 3, "R10 claim highest");
        rd('h80, 'h20, "R10 claim cleared pending");
        chk(irq == 2'b01, "R9 threshold blocks ctx1", int'(irq), 1);
        rd(cla(1), 0, "R9 no eligible source");
        rd(cla(0), 5, "R10 claim next");
        chk(irq == 2'b00, "R9 all claimed", int'(irq), 0);
        rd(cla(0), 0, "R10 empty claim");

        // complete handling
        wr(cla(0), 9);
        pulse(8'h08);
        rd('h80, 'h08, "R6 re-pend while claimed");
        chk(irq == 2'b00, "R11 out-of-range complete ignored", int'(irq), 0);
        wr(cla(0), 3);
        chk(irq == 2'b11, "R11 complete releases", int'(irq), 3);
        wr(cla(0), 5);

        // tie break between sources 2 and 4 (both 6)
        pulse(8'h14);
        rd(cla(0), 2, "R9 tie lowest id");
        rd(cla(0), 4, "R9 tie second");
        rd(cla(0), 3, "R9 then lower prio");
        wr(cla(0), 2); wr(cla(0), 4); wr(cla(0), 3);

        // claim wins over a request at the same edge
        req = 8'h20;
        cyc();
        vld = 1'b1; we = 1'b0; addr = 12'(cla(0));
        cyc();
        vld = 1'b0; req = '0;
        chk(rdata == 5, "R10 claim with request high", int'(rdata), 5);
        rd('h80, 0, "R10 clear beats request");
        wr(cla(0), 5);

        // legalisation, wrap (7) and drop (5)
        wr(pa(6), 6);
        rd(pa(6), 6, "R4 in range");
        chk(rdata5 == 0, "R4 drop above max", int'(rdata5), 0);
        wr(pa(6), 4);
        rd(pa(6), 4, "R4 in range both");
        chk(rdata5 == 4, "R4 legal value kept", int'(rdata5), 4);
        wr(pa(6), 13);
        rd(pa(6), 5, "R4 wrap modulo");
        chk(rdata5 == 4, "R4 drop keeps old", int'(rdata5), 4);
        wr(tha(0), 9);
        rd(tha(0), 1, "R4 threshold wrap");
        chk(rdata5 == 0, "R4 threshold drop", int'(rdata5), 0);
        wr(tha(0), 0);

        // reserved source 0
        wr(pa(0), 7);
        rd(pa(0), 0, "R3 source0 priority fixed");

        // pending is read-only, bit 0 ignored
        wr(pa(6), 0);
        pulse(8'h41);
        wr('h80, 'hFF);
        rd('h80, 'h40, "R5 pending read-only and bit0 low");

        // enable word bounds
        wr(ena(0, 1), 'hFF);
        rd(ena(0, 1), 0, "R7 word beyond count");
        rd(ena(0, 0), 'h3C, "R7 in-range word untouched");
        wr(ena(0, 0), 32'hFFFF_FF00);
        rd(ena(0, 0), 0, "R7 missing sources read zero");

        // context block holes and unmapped space
        wr(tha(0) + 8, 3);
        rd(tha(0) + 8, 0, "R8 unused context offset");
        rd(tha(0), 0, "R8 threshold untouched");
        wr('h300, 5);
        rd('h300, 0, "R2 unmapped read");
        rd(pa(3) + 1, 0, "R2 misaligned read");
        rd(pa(3), 5, "R2 unmapped write harmless");

        repeat (3) cyc();
        summary();
        $finish;
    end

endmodule